// File: doc/BRIEF.md
# Framed byte-link packet receiver

This block turns a byte-wide link stream into complete mesh transactions. Each link clock it samples one byte and a frame bit; double-data-rate capture and pad handling are done upstream. A packet opens when frame goes from low to high. The header byte opened that way sets the packet length and the transaction attributes. The block gathers a destination address, a data word and, in the long form, a return address. When the last byte arrives it presents the whole transaction with a one-cycle strobe.

If frame is still high on the clock after a packet's last byte, the link is streaming. The header and the destination address bytes of the next transaction are not sent. The next transaction reuses the previous header and takes the previous destination plus a fixed stride. The first byte it receives is therefore its data byte (index 5). Separate read and write pushback outputs tell the far transmitter to stop. They follow buffer-full inputs and rise a fixed number of clocks after a packet of the matching kind completes. Decoding continues while pushback is high, so the far end can still finish one more transaction.

Top module: `mesh_link_rx`

## Requirements
- R1: While reset is asserted, `out_access`, `wr_wait` and `rd_wait` are low.
- R2: A byte is taken as a header only when frame is high on that clock and was low on the clock before. Frame held high during reset counts as a high previous sample, so bytes arriving with frame continuously high after reset produce no transaction.
- R3: Header byte layout: bit 0 = long form, bit 1 = write (0 = read), bits 3:2 = datamode (00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit), bits 7:4 = ctrlmode. These values appear on `out_write`, `out_datamode` and `out_ctrlmode`.
- R4: A short packet (bit 0 = 0) has 9 bytes. Bytes 1 to 4 are the destination address and bytes 5 to 8 are the data, each most significant byte first. It completes on byte 8 and reports `out_srcaddr` = 0.
- R5: A long packet (bit 0 = 1) adds bytes 9 to 12, the return address (most significant byte first), and completes on byte 12.
- R6: If frame is sampled low before the last byte of a packet, the packet is discarded and no strobe is produced for it.
- R7: `out_access` is high for exactly one cycle. That cycle begins with the clock edge that samples the last byte. The field outputs hold their values until the next strobe.
- R8: If frame is high on the clock after a last byte, that byte is byte 5 of a new transaction. It keeps the previous header and uses the previous destination plus 8 (modulo 2^32). Its srcaddr is 0 unless it is long. A low frame there ends the chain.
- R9: If `wr_full` (or `rd_full`) is high during the strobe cycle of a write (or read) transaction, `wr_wait` (or `rd_wait`) rises on the second clock edge after the edge that captured the last byte. The other pushback output is unaffected.
- R10: A raised pushback output stays high while its full input stays high. It drops on the first edge that samples the full input low, once no armed rise is pending.
- R11: Packets arriving while a pushback output is high are still decoded completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one byte per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_frame | input | 1 | Frame bit sampled with each byte |
| rx_byte | input | 8 | Received byte |
| wr_full | input | 1 | Write buffer full level |
| rd_full | input | 1 | Read buffer full level |
| out_access | output | 1 | One-cycle transaction valid strobe |
| out_write | output | 1 | 1 = write, 0 = read |
| out_datamode | output | 2 | Access size code |
| out_ctrlmode | output | 4 | Control mode |
| out_dstaddr | output | AW | Destination address |
| out_data | output | DW | Data word |
| out_srcaddr | output | AW | Return address (0 for short packets) |
| wr_wait | output | 1 | Write pushback |
| rd_wait | output | 1 | Read pushback |

## Verification
A wrong byte index or length selection shows up at the very next strobe. Either the strobe lands four clocks early or late, or the fields come out byte-rotated. The full sweep of all 256 header values catches either case within one packet. A stale edge detector or a missing abort shows up as a strobe that should never appear, within one packet length of the bad frame pattern. An incorrect streaming restart shows up on the first chained transaction as a wrong destination or a missing strobe. Pushback pipeline faults are visible two clocks after a completion as a rise that is early, late or on the wrong output.

// File: rtl/mlr_pkg.sv
package mlr_pkg;

   // Header byte: field order is decoded by the assembler, so bit positions matter.
   typedef struct packed {
      logic [3:0] cmode;  // bits 7:4
      logic [1:0] dmode;  // bits 3:2
      logic       wr;     // bit 1
      logic       lng;    // bit 0, long form carries a return address
   } mlr_hdr_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BODY = 1'b1
   } mlr_state_e;

endpackage

// File: rtl/mlr_edge.sv
module mlr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic frame,
   output logic start
);
   logic frame_q;

   // Previous sample resets high: a frame already high at reset is not a rise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_q <= 1'b1;
      else        frame_q <= frame;
   end

   assign start = frame & ~frame_q;
endmodule

// File: rtl/mlr_assemble.sv
module mlr_assemble
   import mlr_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int STRIDE = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          frame,
   input  logic [7:0]    byte_in,
   output logic          done_o,
   output logic          wr_o,
   output logic [1:0]    dm_o,
   output logic [3:0]    cm_o,
   output logic [AW-1:0] dst_o,
   output logic [DW-1:0] dat_o,
   output logic [AW-1:0] src_o
);
   localparam int AB     = AW / 8;
   localparam int DB     = DW / 8;
   localparam int DAT_LO = AB + 1;
   localparam int DAT_HI = AB + DB;
   localparam int SRC_HI = 2 * AB + DB;
   localparam int IDXW   = $clog2(SRC_HI + 1);
   localparam logic [IDXW-1:0] I_DST_HI = IDXW'(AB);
   localparam logic [IDXW-1:0] I_DAT_LO = IDXW'(DAT_LO);
   localparam logic [IDXW-1:0] I_DAT_HI = IDXW'(DAT_HI);
   localparam logic [IDXW-1:0] I_SRC_HI = IDXW'(SRC_HI);

   mlr_state_e    st;
   logic [IDXW-1:0] idx;
   mlr_hdr_t      hdr_q;
   logic [AW-1:0] dst_q, src_q, dst_n, src_n;
   logic [DW-1:0] dat_q, dat_n;
   logic          in_dst, in_dat, in_src, is_last;

   always_comb begin
      in_dst  = (idx <= I_DST_HI);
      in_dat  = (idx >= I_DAT_LO) && (idx <= I_DAT_HI);
      in_src  = (idx > I_DAT_HI);
      dst_n   = in_dst ? {dst_q[AW-9:0], byte_in} : dst_q;
      dat_n   = in_dat ? {dat_q[DW-9:0], byte_in} : dat_q;
      src_n   = in_src ? {src_q[AW-9:0], byte_in} : src_q;
      is_last = (idx == (hdr_q.lng ? I_SRC_HI : I_DAT_HI));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         idx    <= '0;
         hdr_q  <= '0;
         dst_q  <= '0;
         dat_q  <= '0;
         src_q  <= '0;
         done_o <= 1'b0;
         wr_o   <= 1'b0;
         dm_o   <= '0;
         cm_o   <= '0;
         dst_o  <= '0;
         dat_o  <= '0;
         src_o  <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  hdr_q <= mlr_hdr_t'(byte_in);
                  dst_q <= '0;
                  dat_q <= '0;
                  src_q <= '0;
                  idx   <= IDXW'(1);
                  st    <= ST_BODY;
               end
            end
            ST_BODY: begin
               if (!frame) begin
                  // Either a mid-packet drop (discard) or the end of a chain.
                  st <= ST_IDLE;
               end else if (is_last) begin
                  done_o <= 1'b1;
                  wr_o   <= hdr_q.wr;
                  dm_o   <= hdr_q.dmode;
                  cm_o   <= hdr_q.cmode;
                  dst_o  <= dst_n;
                  dat_o  <= dat_n;
                  src_o  <= src_n;
                  // Prepare a possible streamed follower starting at its data bytes.
                  dst_q  <= dst_n + AW'(STRIDE);
                  dat_q  <= dat_n;
                  src_q  <= '0;
                  idx    <= I_DAT_LO;
               end else begin
                  dst_q <= dst_n;
                  dat_q <= dat_n;
                  src_q <= src_n;
                  idx   <= idx + IDXW'(1);
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/mlr_wait.sv
module mlr_wait #(
   parameter int LAG = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic full_i,
   output logic wait_o
);
   logic [LAG-2:0] stg;

   generate
      if (LAG == 2) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg[0] <= evt_i & full_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[LAG-3:0], evt_i & full_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_o <= 1'b0;
      else        wait_o <= stg[LAG-2] | (wait_o & full_i);
   end
endmodule

// File: rtl/mesh_link_rx.sv
module mesh_link_rx
   import mlr_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int STRIDE   = 8,
   parameter int WAIT_LAG = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_frame,
   input  logic [7:0]    rx_byte,
   input  logic          wr_full,
   input  logic          rd_full,
   output logic          out_access,
   output logic          out_write,
   output logic [1:0]    out_datamode,
   output logic [3:0]    out_ctrlmode,
   output logic [AW-1:0] out_dstaddr,
   output logic [DW-1:0] out_data,
   output logic [AW-1:0] out_srcaddr,
   output logic          wr_wait,
   output logic          rd_wait
);
   localparam int NCH = 2;  // channel 0 = write, channel 1 = read

   generate
      if (AW % 8 != 0 || AW < 16) begin : g_bad_aw
         $error("mesh_link_rx: AW must be a multiple of 8 and at least 16");
      end
      if (DW % 8 != 0 || DW < 16) begin : g_bad_dw
         $error("mesh_link_rx: DW must be a multiple of 8 and at least 16");
      end
      if (WAIT_LAG < 2) begin : g_bad_lag
         $error("mesh_link_rx: WAIT_LAG must be at least 2");
      end
   endgenerate

   logic sop;

   mlr_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .frame (rx_frame),
      .start (sop)
   );

   mlr_assemble #(.AW(AW), .DW(DW), .STRIDE(STRIDE)) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sop),
      .frame   (rx_frame),
      .byte_in (rx_byte),
      .done_o  (out_access),
      .wr_o    (out_write),
      .dm_o    (out_datamode),
      .cm_o    (out_ctrlmode),
      .dst_o   (out_dstaddr),
      .dat_o   (out_data),
      .src_o   (out_srcaddr)
   );

   logic [NCH-1:0] ch_evt, ch_full, ch_wait;
   assign ch_evt  = {out_access & ~out_write, out_access & out_write};
   assign ch_full = {rd_full, wr_full};

   for (genvar c = 0; c < NCH; c++) begin : g_wait
      mlr_wait #(.LAG(WAIT_LAG)) u_wait (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_i  (ch_evt[c]),
         .full_i (ch_full[c]),
         .wait_o (ch_wait[c])
      );
   end

   assign wr_wait = ch_wait[0];
   assign rd_wait = ch_wait[1];
endmodule

// File: rtl/mlr_checker.sv
module mlr_checker #(
   parameter int WAIT_LAG = 2
) (
   input logic clk,
   input logic rst_n,
   input logic rx_frame,
   input logic out_access,
   input logic out_write,
   input logic wr_full,
   input logic rd_full,
   input logic wr_wait,
   input logic rd_wait
);
   localparam logic [7:0] SAT = 8'hFF;
   localparam logic [7:0] GAP = 8'(WAIT_LAG - 1);

   // Cycles since the last strobe of each kind (0 in the cycle after the strobe).
   logic [7:0] since_wr, since_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_wr <= SAT;
         since_rd <= SAT;
      end else begin
         if (out_access && out_write)  since_wr <= '0;
         else if (since_wr != SAT)     since_wr <= since_wr + 8'd1;
         if (out_access && !out_write) since_rd <= '0;
         else if (since_rd != SAT)     since_rd <= since_rd + 8'd1;
      end
   end

   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      out_access |=> !out_access);

   a_r6_no_strobe_after_low_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_frame |=> !out_access);

   a_r9_wr_wait_lag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_wait) |-> (since_wr == GAP));

   a_r9_rd_wait_lag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_wait) |-> (since_rd == GAP));

   a_r10_wr_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_full && since_wr >= GAP) |=> !wr_wait);

   a_r10_rd_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_full && since_rd >= GAP) |=> !rd_wait);
endmodule

bind mesh_link_rx mlr_checker #(.WAIT_LAG(WAIT_LAG)) u_mlr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_frame   (rx_frame),
   .out_access (out_access),
   .out_write  (out_write),
   .wr_full    (wr_full),
   .rd_full    (rd_full),
   .wr_wait    (wr_wait),
   .rd_wait    (rd_wait)
);

// File: tb/test_mesh_link_rx.sv
module test_mesh_link_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_frame = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        wr_full = 1'b0;
   logic        rd_full = 1'b0;
   logic        out_access, out_write, wr_wait, rd_wait;
   logic [1:0]  out_datamode;
   logic [3:0]  out_ctrlmode;
   logic [31:0] out_dstaddr, out_data, out_srcaddr;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   mesh_link_rx i_mesh_link_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_frame     (rx_frame),
      .rx_byte      (rx_byte),
      .wr_full      (wr_full),
      .rd_full      (rd_full),
      .out_access   (out_access),
      .out_write    (out_write),
      .out_datamode (out_datamode),
      .out_ctrlmode (out_ctrlmode),
      .out_dstaddr  (out_dstaddr),
      .out_data     (out_data),
      .out_srcaddr  (out_srcaddr),
      .wr_wait      (wr_wait),
      .rd_wait      (rd_wait)
   );

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_up();
   end

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One byte per clock: drive after a falling edge, return after the next falling edge.
   task automatic put(input logic f, input logic [7:0] b);
      rx_frame = f;
      rx_byte  = b;
      @(negedge clk);
   endtask

   function automatic logic [127:0] got();
      return {24'b0, out_access, out_write, out_datamode, out_ctrlmode,
              out_dstaddr, out_data, out_srcaddr};
   endfunction

   function automatic logic [127:0] mk(input logic wr, input logic [1:0] dm,
                                       input logic [3:0] cm, input logic [31:0] dst,
                                       input logic [31:0] dat, input logic [31:0] src);
      return {24'b0, 1'b1, wr, dm, cm, dst, dat, src};
   endfunction

   task automatic send_body(input logic [31:0] dst, input logic [31:0] dat,
                            input logic [31:0] src, input logic lng,
                            input logic from5, output logic early);
      logic [7:0] bl [12];
      int n = 0;
      if (!from5)
         for (int i = 0; i < 4; i++) begin bl[n] = dst[31-8*i -: 8]; n++; end
      for (int i = 0; i < 4; i++) begin bl[n] = dat[31-8*i -: 8]; n++; end
      if (lng)
         for (int i = 0; i < 4; i++) begin bl[n] = src[31-8*i -: 8]; n++; end
      early = 1'b0;
      for (int k = 0; k < n; k++) begin
         put(1'b1, bl[k]);
         if (k < n - 1 && out_access) early = 1'b1;
      end
   endtask

   task automatic pkt(input string req, input logic [7:0] hdr, input logic [31:0] dst,
                      input logic [31:0] dat, input logic [31:0] src);
      logic e0, e1;
      put(1'b0, 8'h00);
      put(1'b1, hdr);
      e0 = out_access;
      send_body(dst, dat, src, hdr[0], 1'b0, e1);
      chk(req, "early strobe", {127'b0, e0 | e1}, 128'b0);
      chk(req, "fields", got(), mk(hdr[1], hdr[3:2], hdr[7:4], dst, dat,
                                   hdr[0] ? src : 32'h0));
   endtask

   task automatic stream(input string req, input logic [7:0] hdr, input logic [31:0] dst_exp,
                         input logic [31:0] dat, input logic [31:0] src);
      logic e;
      send_body(dst_exp, dat, src, hdr[0], 1'b1, e);
      chk(req, "early strobe in chain", {127'b0, e}, 128'b0);
      chk(req, "chained fields", got(), mk(hdr[1], hdr[3:2], hdr[7:4], dst_exp, dat,
                                           hdr[0] ? src : 32'h0));
   endtask

   initial begin
      // R1: reset state, with frame held high through reset
      rx_frame = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "outputs in reset", {125'b0, out_access, wr_wait, rd_wait}, 128'b0);
      rst_n = 1'b1;

      // R2: frame high since reset is not a rising edge
      begin
         logic seen = 1'b0;
         for (int i = 0; i < 16; i++) begin
            put(1'b1, 8'(8'h01 + i));
            seen |= out_access;
         end
         chk("R2", "strobe without frame rise", {127'b0, seen}, 128'b0);
      end

      // R3 R4 R5 R7: sweep every header value
      for (int h = 0; h < 256; h++) begin
         logic [31:0] d, v, s;
         d = 32'h1000_0000 + 32'(h) * 32'h0101_0103;
         v = (32'(h) * 32'h0003_0007) ^ 32'hA5A5_0000;
         s = ~d;
         pkt(h[0] ? "R3 R5" : "R3 R4", h[7:0], d, v, s);
         put(1'b0, 8'h00);
         chk("R7", "strobe width", {127'b0, out_access}, 128'b0);
      end

      // R6: drop frame at every position of a long packet
      for (int p = 1; p <= 12; p++) begin
         logic seen = 1'b0;
         put(1'b0, 8'h00);
         put(1'b1, 8'hC5);
         for (int i = 1; i < p; i++) begin
            put(1'b1, 8'(8'h40 + i));
            seen |= out_access;
         end
         for (int i = 0; i < 14; i++) begin
            put(1'b0, 8'(8'h50 + i));
            seen |= out_access;
         end
         chk("R6", "strobe after mid-packet drop", {127'b0, seen}, 128'b0);
      end
      pkt("R6", 8'hC5, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0BAD_F00D);
      put(1'b0, 8'h00);

      // R8: short chain
      pkt("R8", 8'h5A, 32'h0000_1000, 32'h1111_1111, 32'h0000_DEAD);
      for (int k = 1; k <= 3; k++)
         stream("R8", 8'h5A, 32'h0000_1000 + 32'(8 * k), 32'h1111_1111 * 32'(k + 1), 32'h0);
      put(1'b0, 8'h00);
      chk("R8", "chain end strobe", {127'b0, out_access}, 128'b0);
      // R8: long chain with address wrap
      pkt("R8", 8'h9D, 32'hFFFF_FFF0, 32'hCAFE_0001, 32'h7000_0001);
      stream("R8", 8'h9D, 32'hFFFF_FFF8, 32'hCAFE_0002, 32'h7000_0002);
      stream("R8", 8'h9D, 32'h0000_0000, 32'hCAFE_0003, 32'h7000_0003);
      begin
         logic seen = 1'b0;
         for (int i = 0; i < 14; i++) begin
            put(1'b0, 8'hEE);
            seen |= out_access;
         end
         chk("R8", "no strobe after chain end", {127'b0, seen}, 128'b0);
      end

      // R9: write pushback timing
      wr_full = 1'b1;
      pkt("R9", 8'h5A, 32'h0000_2000, 32'h2222_2222, 32'h0);
      chk("R9", "wr_wait at strobe", {127'b0, wr_wait}, 128'b0);
      put(1'b0, 8'h00);
      chk("R9", "wr_wait one edge later", {127'b0, wr_wait}, 128'b0);
      put(1'b0, 8'h00);
      chk("R9", "wr_wait two edges later", {126'b0, wr_wait, rd_wait}, 128'b10);
      // R10: held while full
      for (int i = 0; i < 3; i++) begin
         put(1'b0, 8'h00);
         chk("R10", "wr_wait held", {127'b0, wr_wait}, 128'b1);
      end
      // R11: one more transaction still accepted
      pkt("R11", 8'h5A, 32'h0000_3000, 32'h3333_3333, 32'h0);
      chk("R11", "wr_wait during extra packet", {127'b0, wr_wait}, 128'b1);
      for (int i = 0; i < 4; i++) put(1'b0, 8'h00);
      wr_full = 1'b0;
      put(1'b0, 8'h00);
      chk("R10", "wr_wait release", {127'b0, wr_wait}, 128'b0);

      // R9: read pushback, write side untouched even with wr_full high
      rd_full = 1'b1;
      wr_full = 1'b1;
      pkt("R9", 8'h29, 32'h0000_4000, 32'h4444_4444, 32'h5555_5555);
      put(1'b0, 8'h00);
      chk("R9", "rd_wait one edge later", {126'b0, wr_wait, rd_wait}, 128'b0);
      put(1'b0, 8'h00);
      chk("R9", "rd_wait two edges later", {126'b0, wr_wait, rd_wait}, 128'b01);
      rd_full = 1'b0;
      wr_full = 1'b0;
      put(1'b0, 8'h00);
      chk("R10", "rd_wait release", {126'b0, wr_wait, rd_wait}, 128'b0);

      finish_up();
   end
endmodule